// File: doc/BRIEF.md
# Configurable Cache Replacement Policy Unit

This block chooses which way of a set-associative cache is overwritten when a line has to be filled. It also holds the replacement history for every set. The cache has 2^NWAY_W ways and 2^NLINE_W sets. When a hit is signalled, the block takes the set index and a one-hot vector of the way that was accessed, and updates that set's history at the next clock edge. On a separate query port, the block takes a set index and presents the way to evict for that set. The victim appears both as a one-hot vector and as a binary index.

The policy is chosen by a parameter when the design is elaborated. The choices are:
- true least-recently-used, which keeps an age counter per way;
- a pseudo-LRU that keeps one recently-used flag per way;
- a pseudo-LRU that keeps a binary decision tree per set.

The block does not hold tags, data or valid bits, and it does not detect misses. It is only instantiated in the associative configuration of a cache.

Top module: `repl_policy_unit`

## Requirements
- R1: The history of each set is separate. An update to one set never changes the victim reported for any other set.
- R2: After the asynchronous reset `rst_ni` is asserted, and until the first update, every set reports way 0 as its victim. In this state the age of way j is j (true LRU), all flags are 0 (flag PLRU) and all tree nodes are 0 (tree PLRU).
- R3: `victim_oh_o` always has exactly one bit set, and `victim_idx_o` is the binary position of that bit.
- R4: In the cycle after an update to set L with way w, a query of set L does not report way w as the victim.
- R5: With POLICY=1 (flag PLRU), an update sets the flag of the accessed way. If that would leave all flags at 1, only the accessed way's flag stays at 1. The victim is the lowest-numbered way whose flag is 0.
- R6: With POLICY=2 (tree PLRU), the N-1 nodes form a heap: node 1 is the root, and node n has children 2n (lower ways) and 2n+1 (upper ways). An update sets each node on the accessed way's path to point to the other half: 1 means upper, 0 means lower. The victim is found by following the node values down from the root.
- R7: With POLICY=0 (true LRU), the accessed way takes age N-1. Every way whose age was above the accessed way's old age drops by 1. The victim is the way whose age is 0.
- R8: Updates take effect at the clock edge where `upd_en_i` is 1. The victim output depends combinationally on `qry_line_i` and the stored history. When `upd_en_i` is 0, `upd_line_i` and `upd_way_i` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| upd_en_i | input | 1 | Record an access on this edge |
| upd_line_i | input | NLINE_W | Set index of the access |
| upd_way_i | input | 2^NWAY_W | One-hot way that was accessed |
| qry_line_i | input | NLINE_W | Set index whose victim is requested |
| victim_oh_o | output | 2^NWAY_W | One-hot victim way |
| victim_idx_o | output | NWAY_W | Binary victim way |

## Verification
The victim outputs depend combinationally on `qry_line_i`, so they are due in the same cycle as the query. An update is seen from the first query that follows the clock edge at which `upd_en_i` was high. The bench changes inputs on the falling edge, compares the outputs 2 ns later, and advances its behavioural age, flag and tree models only at the rising edge. This puts every comparison exactly one edge after the update it depends on. Three instances, one per policy, receive the same stimulus. Fixed sequences, whose results were worked out by hand, cover reset, the wrap of the flag policy, set independence and ignored updates.

// File: rtl/repl_pkg.sv
package repl_pkg;
  typedef enum logic [1:0] {
    POL_LRU  = 2'd0,
    POL_BIT  = 2'd1,
    POL_TREE = 2'd2
  } repl_policy_e;
endpackage

// File: rtl/repl_onehot_enc.sv
module repl_onehot_enc #(
  parameter int IDX_W = 2,
  localparam int N = 1 << IDX_W
) (
  input  logic [N-1:0]     oh_i,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int b = 0; b < IDX_W; b++) begin
      for (int i = 0; i < N; i++) begin
        if (((i >> b) & 1) == 1) idx_o[b] = idx_o[b] | oh_i[i];
      end
    end
  end
endmodule

// File: rtl/repl_state_mem.sv
module repl_state_mem #(
  parameter int LINE_W = 3,
  parameter int SW = 4,
  parameter logic [SW-1:0] RST_VAL = '0,
  localparam int LINES = 1 << LINE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [LINE_W-1:0] waddr_i,
  input  logic [SW-1:0]     wdata_i,
  input  logic [LINE_W-1:0] raddr_a_i,
  output logic [SW-1:0]     rdata_a_o,
  input  logic [LINE_W-1:0] raddr_b_i,
  output logic [SW-1:0]     rdata_b_o
);
  logic [SW-1:0] mem_q [LINES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int l = 0; l < LINES; l++) mem_q[l] <= RST_VAL;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_a_o = mem_q[raddr_a_i];
  assign rdata_b_o = mem_q[raddr_b_i];
endmodule

// File: rtl/repl_lru_logic.sv
module repl_lru_logic #(
  parameter int W = 2,
  localparam int N = 1 << W,
  localparam int SW = N * W
) (
  input  logic [SW-1:0] cur_upd_i,
  input  logic [N-1:0]  way_oh_i,
  output logic [SW-1:0] nxt_o,
  input  logic [SW-1:0] cur_qry_i,
  output logic [N-1:0]  victim_oh_o
);
  logic [W-1:0] acc_age;

  // age of the accessed way, selected by the one-hot vector
  always_comb begin
    acc_age = '0;
    for (int j = 0; j < N; j++) begin
      if (way_oh_i[j]) acc_age = acc_age | cur_upd_i[j*W +: W];
    end
  end

  always_comb begin
    nxt_o = cur_upd_i;
    for (int j = 0; j < N; j++) begin
      if (way_oh_i[j]) nxt_o[j*W +: W] = '1;
      else if (cur_upd_i[j*W +: W] > acc_age) nxt_o[j*W +: W] = cur_upd_i[j*W +: W] - 1'b1;
    end
  end

  always_comb begin
    for (int j = 0; j < N; j++) victim_oh_o[j] = (cur_qry_i[j*W +: W] == '0);
  end
endmodule

// File: rtl/repl_bit_plru_logic.sv
module repl_bit_plru_logic #(
  parameter int W = 2,
  localparam int N = 1 << W
) (
  input  logic [N-1:0] cur_upd_i,
  input  logic [N-1:0] way_oh_i,
  output logic [N-1:0] nxt_o,
  input  logic [N-1:0] cur_qry_i,
  output logic [N-1:0] victim_oh_o
);
  logic [N-1:0] merged;
  logic         found;

  assign merged = cur_upd_i | way_oh_i;
  assign nxt_o  = (&merged) ? way_oh_i : merged;

  always_comb begin
    victim_oh_o = '0;
    found = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (!cur_qry_i[i] && !found) begin
        victim_oh_o[i] = 1'b1;
        found = 1'b1;
      end
    end
  end
endmodule

// File: rtl/repl_tree_plru_logic.sv
module repl_tree_plru_logic #(
  parameter int W = 2,
  localparam int N = 1 << W,
  localparam int SW = N - 1
) (
  input  logic [SW-1:0] cur_upd_i,
  input  logic [N-1:0]  way_oh_i,
  output logic [SW-1:0] nxt_o,
  input  logic [SW-1:0] cur_qry_i,
  output logic [N-1:0]  victim_oh_o
);
  logic [W-1:0] way_idx;

  repl_onehot_enc #(.IDX_W(W)) u_upd_enc (
    .oh_i  (way_oh_i),
    .idx_o (way_idx)
  );

  // heap node n is stored at bit n-1
  always_comb begin
    int node;
    nxt_o = cur_upd_i;
    for (int l = 0; l < W; l++) begin
      node = (1 << l) | (int'(way_idx) >> (W - l));
      nxt_o[node-1] = ~way_idx[W-1-l];
    end
  end

  always_comb begin
    int n;
    n = 1;
    for (int l = 0; l < W; l++) n = 2 * n + int'(cur_qry_i[n-1]);
    victim_oh_o = N'(1) << (n - N);
  end
endmodule

// File: rtl/repl_policy_unit.sv
module repl_policy_unit #(
  parameter int NWAY_W = 2,
  parameter int NLINE_W = 3,
  parameter repl_pkg::repl_policy_e POLICY = repl_pkg::POL_LRU,
  localparam int N = 1 << NWAY_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               upd_en_i,
  input  logic [NLINE_W-1:0] upd_line_i,
  input  logic [N-1:0]       upd_way_i,
  input  logic [NLINE_W-1:0] qry_line_i,
  output logic [N-1:0]       victim_oh_o,
  output logic [NWAY_W-1:0]  victim_idx_o
);
  import repl_pkg::*;

  localparam int SW = (POLICY == POL_LRU) ? N * NWAY_W :
                      (POLICY == POL_BIT) ? N : N - 1;

  function automatic logic [SW-1:0] init_state();
    logic [SW-1:0] r;
    r = '0;
    if (POLICY == POL_LRU) begin
      for (int j = 0; j < N; j++) r[j*NWAY_W +: NWAY_W] = NWAY_W'(j);
    end
    return r;
  endfunction

  localparam logic [SW-1:0] RST_STATE = init_state();

  logic [SW-1:0] cur_upd, cur_qry, nxt_state;

  repl_state_mem #(
    .LINE_W  (NLINE_W),
    .SW      (SW),
    .RST_VAL (RST_STATE)
  ) u_state (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (upd_en_i),
    .waddr_i   (upd_line_i),
    .wdata_i   (nxt_state),
    .raddr_a_i (upd_line_i),
    .rdata_a_o (cur_upd),
    .raddr_b_i (qry_line_i),
    .rdata_b_o (cur_qry)
  );

  generate
    if (POLICY == POL_LRU) begin : g_lru
      repl_lru_logic #(.W(NWAY_W)) u_pol (
        .cur_upd_i   (cur_upd),
        .way_oh_i    (upd_way_i),
        .nxt_o       (nxt_state),
        .cur_qry_i   (cur_qry),
        .victim_oh_o (victim_oh_o)
      );
    end else if (POLICY == POL_BIT) begin : g_bit
      repl_bit_plru_logic #(.W(NWAY_W)) u_pol (
        .cur_upd_i   (cur_upd),
        .way_oh_i    (upd_way_i),
        .nxt_o       (nxt_state),
        .cur_qry_i   (cur_qry),
        .victim_oh_o (victim_oh_o)
      );
    end else begin : g_tree
      repl_tree_plru_logic #(.W(NWAY_W)) u_pol (
        .cur_upd_i   (cur_upd),
        .way_oh_i    (upd_way_i),
        .nxt_o       (nxt_state),
        .cur_qry_i   (cur_qry),
        .victim_oh_o (victim_oh_o)
      );
    end
  endgenerate

  repl_onehot_enc #(.IDX_W(NWAY_W)) u_vic_enc (
    .oh_i  (victim_oh_o),
    .idx_o (victim_idx_o)
  );
endmodule

// File: rtl/repl_policy_unit_chk.sv
module repl_policy_unit_chk #(
  parameter int NWAY_W = 2,
  parameter int NLINE_W = 3,
  localparam int N = 1 << NWAY_W
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               upd_en_i,
  input logic [NLINE_W-1:0] upd_line_i,
  input logic [N-1:0]       upd_way_i,
  input logic [NLINE_W-1:0] qry_line_i,
  input logic [N-1:0]       victim_oh_o,
  input logic [NWAY_W-1:0]  victim_idx_o
);
  logic any_upd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) any_upd_q <= 1'b0;
    else if (upd_en_i) any_upd_q <= 1'b1;
  end

  a_r3_victim_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(victim_oh_o) == 1);

  a_r3_idx_matches: assert property (@(posedge clk_i) disable iff (!rst_ni)
    victim_oh_o[victim_idx_o] == 1'b1);

  a_r2_reset_victim_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !any_upd_q |-> victim_idx_o == '0);

  a_r4_accessed_not_victim: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_en_i |=> (qry_line_i != $past(upd_line_i)) || (victim_oh_o != $past(upd_way_i)));

  a_r8_hold_without_update: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_en_i |=> (qry_line_i != $past(qry_line_i)) || $stable(victim_oh_o));
endmodule

bind repl_policy_unit repl_policy_unit_chk #(
  .NWAY_W  (NWAY_W),
  .NLINE_W (NLINE_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .upd_en_i     (upd_en_i),
  .upd_line_i   (upd_line_i),
  .upd_way_i    (upd_way_i),
  .qry_line_i   (qry_line_i),
  .victim_oh_o  (victim_oh_o),
  .victim_idx_o (victim_idx_o)
);

// File: tb/repl_policy_unit_test.sv
`timescale 1ns/1ps
module repl_policy_unit_test;
  localparam int WW = 2;
  localparam int LW = 3;
  localparam int N = 1 << WW;
  localparam int LINES = 1 << LW;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic upd_en = 1'b0;
  logic [LW-1:0] upd_line = '0;
  logic [N-1:0] upd_way = '0;
  logic [LW-1:0] qry_line = '0;
  logic [N-1:0] oh_lru, oh_bit, oh_tree;
  logic [WW-1:0] ix_lru, ix_bit, ix_tree;

  always #10 clk = ~clk;

  repl_policy_unit #(.NWAY_W(WW), .NLINE_W(LW), .POLICY(repl_pkg::POL_LRU)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .upd_en_i(upd_en), .upd_line_i(upd_line),
    .upd_way_i(upd_way), .qry_line_i(qry_line), .victim_oh_o(oh_lru), .victim_idx_o(ix_lru));
  repl_policy_unit #(.NWAY_W(WW), .NLINE_W(LW), .POLICY(repl_pkg::POL_BIT)) uut_bit (
    .clk_i(clk), .rst_ni(rst_ni), .upd_en_i(upd_en), .upd_line_i(upd_line),
    .upd_way_i(upd_way), .qry_line_i(qry_line), .victim_oh_o(oh_bit), .victim_idx_o(ix_bit));
  repl_policy_unit #(.NWAY_W(WW), .NLINE_W(LW), .POLICY(repl_pkg::POL_TREE)) uut_tree (
    .clk_i(clk), .rst_ni(rst_ni), .upd_en_i(upd_en), .upd_line_i(upd_line),
    .upd_way_i(upd_way), .qry_line_i(qry_line), .victim_oh_o(oh_tree), .victim_idx_o(ix_tree));

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  // behavioural models
  int age [LINES][N];
  bit mru [LINES][N];
  bit tnode [LINES][N];

  int cur_en = 0, cur_line = 0, cur_w = 0;
  int prv_en = 0, prv_line = 0, prv_w = 0;

  function automatic int lru_vic(int ln);
    for (int j = 0; j < N; j++) if (age[ln][j] == 0) return j;
    return -1;
  endfunction

  function automatic int bit_vic(int ln);
    for (int j = 0; j < N; j++) if (!mru[ln][j]) return j;
    return -1;
  endfunction

  function automatic int tree_vic(int ln);
    int lo = 0, hi = N, n = 1, mid;
    while (hi - lo > 1) begin
      mid = (lo + hi) / 2;
      if (tnode[ln][n]) begin lo = mid; n = 2 * n + 1; end
      else begin hi = mid; n = 2 * n; end
    end
    return lo;
  endfunction

  function automatic int model_vic(int p, int ln);
    if (p == 0) return lru_vic(ln);
    if (p == 1) return bit_vic(ln);
    return tree_vic(ln);
  endfunction

  function automatic int get_oh(int p);
    if (p == 0) return int'(oh_lru);
    if (p == 1) return int'(oh_bit);
    return int'(oh_tree);
  endfunction

  function automatic int get_ix(int p);
    if (p == 0) return int'(ix_lru);
    if (p == 1) return int'(ix_bit);
    return int'(ix_tree);
  endfunction

  task automatic model_reset();
    for (int l = 0; l < LINES; l++)
      for (int j = 0; j < N; j++) begin
        age[l][j] = j; mru[l][j] = 0; tnode[l][j] = 0;
      end
  endtask

  task automatic model_update(int ln, int w);
    int a, all, lo, hi, n, mid;
    a = age[ln][w];
    for (int j = 0; j < N; j++) begin
      if (j == w) age[ln][j] = N - 1;
      else if (age[ln][j] > a) age[ln][j]--;
    end
    mru[ln][w] = 1;
    all = 1;
    for (int j = 0; j < N; j++) if (!mru[ln][j]) all = 0;
    if (all == 1) for (int j = 0; j < N; j++) mru[ln][j] = (j == w);
    lo = 0; hi = N; n = 1;
    while (hi - lo > 1) begin
      mid = (lo + hi) / 2;
      if (w < mid) begin tnode[ln][n] = 1; hi = mid; n = 2 * n; end
      else begin tnode[ln][n] = 0; lo = mid; n = 2 * n + 1; end
    end
  endtask

  task automatic chk(string tag, string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic string pol_tag(int p);
    if (p == 0) return "R7";
    if (p == 1) return "R5";
    return "R6";
  endfunction

  task automatic compare_all();
    int e;
    for (int p = 0; p < 3; p++) begin
      e = model_vic(p, int'(qry_line));
      chk(pol_tag(p), $sformatf("policy %0d victim one-hot line %0d", p, qry_line), get_oh(p), 1 << e);
      chk("R3", $sformatf("policy %0d victim index", p), get_ix(p), e);
    end
  endtask

  task automatic finish_test();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  // one cycle: apply the previous edge to the model, drive new inputs, compare
  task automatic do_cycle(int en, int ln, int w, int q);
    @(posedge clk);
    if (cur_en != 0) model_update(cur_line, cur_w);
    prv_en = cur_en; prv_line = cur_line; prv_w = cur_w;
    @(negedge clk);
    cur_en = en; cur_line = ln; cur_w = w;
    upd_en = (en != 0);
    upd_line = LW'(ln);
    upd_way = N'(1) << w;
    qry_line = LW'(q);
    #2;
    compare_all();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_test();
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R2: every set reports way 0 after reset
    for (int l = 0; l < LINES; l++) begin
      do_cycle(0, 0, 0, l);
      chk("R2", "lru reset victim", int'(ix_lru), 0);
      chk("R2", "bit reset victim", int'(ix_bit), 0);
      chk("R2", "tree reset victim", int'(ix_tree), 0);
    end

    // access way 0 of set 3
    do_cycle(1, 3, 0, 3);
    do_cycle(0, 0, 0, 3);
    chk("R7", "lru after way0", int'(ix_lru), 1);
    chk("R5", "bit after way0", int'(ix_bit), 1);
    chk("R6", "tree after way0", int'(ix_tree), 2);
    // R8: disabled update with other way must not change set 3
    do_cycle(0, 3, 2, 3);
    do_cycle(0, 3, 1, 3);
    chk("R8", "lru ignores disabled update", int'(ix_lru), 1);
    chk("R8", "bit ignores disabled update", int'(ix_bit), 1);
    chk("R8", "tree ignores disabled update", int'(ix_tree), 2);
    // R1: set 2 untouched
    do_cycle(0, 0, 0, 2);
    chk("R1", "lru other set", int'(ix_lru), 0);
    chk("R1", "bit other set", int'(ix_bit), 0);
    chk("R1", "tree other set", int'(ix_tree), 0);
    // access way 2 of set 3
    do_cycle(1, 3, 2, 3);
    do_cycle(0, 0, 0, 3);
    chk("R7", "lru after way2", int'(ix_lru), 1);
    chk("R5", "bit after way2", int'(ix_bit), 1);
    chk("R6", "tree after way2", int'(ix_tree), 1);

    // R5: flag wrap on set 5
    do_cycle(1, 5, 0, 5);
    do_cycle(1, 5, 1, 5);
    do_cycle(1, 5, 2, 5);
    do_cycle(0, 0, 0, 5);
    chk("R5", "bit three flags set", int'(ix_bit), 3);
    do_cycle(1, 5, 3, 5);
    do_cycle(0, 0, 0, 5);
    chk("R5", "bit wrap keeps only way3", int'(ix_bit), 0);

    // random traffic with R4 check
    for (int i = 0; i < 3000; i++) begin
      int ln, q;
      ln = $urandom_range(0, LINES - 1);
      q = ($urandom_range(0, 1) == 1) ? ln : $urandom_range(0, LINES - 1);
      do_cycle(($urandom_range(0, 3) != 0) ? 1 : 0, ln, $urandom_range(0, N - 1), q);
      if (prv_en != 0 && int'(qry_line) == prv_line) begin
        chk("R4", "lru accessed way not victim", int'(ix_lru == WW'(prv_w)), 0);
        chk("R4", "bit accessed way not victim", int'(ix_bit == WW'(prv_w)), 0);
        chk("R4", "tree accessed way not victim", int'(ix_tree == WW'(prv_w)), 0);
      end
    end

    finish_test();
  end
endmodule